// File: doc/BRIEF.md
# Banked Register File

This block is the general-register and special-register store of a small 8-bit/16-bit microcontroller core. Its core is a 32-byte window split into four banks of eight byte registers. Two bank-select bits in the status byte choose which bank the register codes reach. Within the active bank the core can reach each byte by name, or reach adjacent byte pairs as 16-bit words with the high byte first. The block also holds the special registers: a 16-bit stack pointer, the status byte, two segment bytes (ES and CS), a mirror-control byte (PMC) and a memory-select byte (MEM). A small evaluator reads the zero and carry flags and reports whether a branch condition holds.

One synchronous write port and one combinational read port share a 5-bit register code. A second combinational port reads any of the 32 bytes by flat address, whatever bank is selected, so the whole window can be inspected. Writing the stack pointer with an odd value stores it with bit 0 cleared and raises a warning pulse for one cycle.

Top module: `bankreg_file`

## Requirements
- R1: On reset every one of the 32 bytes holds 0x11, the status byte is 0x06, ES is 0x0F, CS, PMC and MEM are 0x00, the stack pointer is 0x0000 and `sp_misalign` is low.
- R2: Byte codes 1..8 name the slots X, A, C, B, E, D, L, H, which are slots 0..7 of the active bank. The bank number is 2*status[5] + status[3]. Bank n occupies flat addresses (3-n)*8 .. (3-n)*8+7, and `dbg_data` shows the byte at flat address `dbg_addr`.
- R3: Pair codes 9..12 (AX, BC, DE, HL) join slots 2p+1 (high) and 2p (low) of the active bank, where p = code-9. A read returns high*256+low. A write stores wr_data[15:8] in the high slot and wr_data[7:0] in the low slot.
- R4: A byte read returns the byte zero-extended to 16 bits. A byte write stores wr_data[7:0] and ignores wr_data[15:8].
- R5: Writes take effect at the rising clock edge and reads are combinational. A status write that changes the bank bits redirects register accesses from the next cycle on; in the cycle of that write, reads still use the old bank.
- R6: Code 14 is the stack pointer. A write stores wr_data with bit 0 forced to 0, and a read returns the stored 16-bit value.
- R7: `sp_misalign` is high for exactly the one cycle that follows a stack-pointer write with wr_data[0]=1, and low at all other times.
- R8: Codes 13 (status), 15 (ES), 16 (CS), 17 (PMC) and 18 (MEM) are byte registers. A write stores wr_data[7:0] and a read returns the byte zero-extended.
- R9: Code 0 and codes 19..31 read as 0. Writes to them change no register.
- R10: With Z = status[6] and CY = status[0], `cond_true` is CY for cond_sel 2, !CY for 3, Z for 4, !Z for 5, !(Z|CY) for 6 and Z|CY for 7.
- R11: cond_sel 0 reports `cond_operand` != 0 and cond_sel 1 reports `cond_operand` == 0, whatever the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_sel | input | 5 | Register code being written |
| wr_data | input | 16 | Write value (byte targets use bits 7:0) |
| rd_sel | input | 5 | Register code being read |
| rd_data | output | 16 | Read value, combinational |
| dbg_addr | input | 5 | Flat byte address into the 32-byte window |
| dbg_data | output | 8 | Byte at `dbg_addr` |
| cond_sel | input | 3 | Branch condition code |
| cond_operand | input | 16 | Operand tested by the true/false conditions |
| cond_true | output | 1 | Condition result |
| sp_misalign | output | 1 | One-cycle warning after an odd stack-pointer write |

## Verification
Reads and condition results are combinational, so they are checked in the same cycle the selects are driven. Each write becomes visible from the first sample after the rising edge that takes it. Inputs change on the falling edge and outputs are sampled 1 ns later. A write's result is therefore read at the falling edge just after its capturing edge, and `sp_misalign` is checked at that same point, then again one cycle later, when it must have dropped. The bank-switch timing is checked on both sides of the edge: during the status write the old bank must still answer, and right after it the new bank must.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 16;
  localparam int SEL_W    = 5;
  localparam int BANK_W   = 2;
  localparam int SLOT_W   = 3;
  localparam int NUM_BANK = 1 << BANK_W;
  localparam int BANK_SZ  = 1 << SLOT_W;
  localparam int FILE_SZ  = NUM_BANK * BANK_SZ;
  localparam int FILE_AW  = BANK_W + SLOT_W;
  localparam int COND_W   = 3;

  // register codes shared with the decoder of the core
  localparam logic [SEL_W-1:0] SEL_NONE = 5'd0;
  localparam logic [SEL_W-1:0] SEL_X    = 5'd1;
  localparam logic [SEL_W-1:0] SEL_H    = 5'd8;
  localparam logic [SEL_W-1:0] SEL_AX   = 5'd9;
  localparam logic [SEL_W-1:0] SEL_HL   = 5'd12;
  localparam logic [SEL_W-1:0] SEL_PSW  = 5'd13;
  localparam logic [SEL_W-1:0] SEL_SP   = 5'd14;
  localparam logic [SEL_W-1:0] SEL_ES   = 5'd15;
  localparam logic [SEL_W-1:0] SEL_CS   = 5'd16;
  localparam logic [SEL_W-1:0] SEL_PMC  = 5'd17;
  localparam logic [SEL_W-1:0] SEL_MEM  = 5'd18;

  // status byte bit positions
  localparam int ST_CY   = 0;
  localparam int ST_BNK0 = 3;
  localparam int ST_BNK1 = 5;
  localparam int ST_Z    = 6;

  localparam logic [BYTE_W-1:0] FILL_RST = 8'h11;
  localparam logic [BYTE_W-1:0] PSW_RST  = 8'h06;
  localparam logic [BYTE_W-1:0] ES_RST   = 8'h0F;
  localparam logic [BYTE_W-1:0] CS_RST   = 8'h00;
  localparam logic [BYTE_W-1:0] PMC_RST  = 8'h00;
  localparam logic [BYTE_W-1:0] MEM_RST  = 8'h00;
  localparam logic [WORD_W-1:0] SP_RST   = 16'h0000;

  typedef enum logic [COND_W-1:0] {
    CC_NONZERO = 3'd0,
    CC_ISZERO  = 3'd1,
    CC_CARRY   = 3'd2,
    CC_NOCARRY = 3'd3,
    CC_ZFLAG   = 3'd4,
    CC_NOZFLAG = 3'd5,
    CC_HIGHER  = 3'd6,
    CC_NOTHIGH = 3'd7
  } cond_e;

  // bank n starts at (NUM_BANK-1-n)*BANK_SZ: the inverted bank number is the upper address
  function automatic logic [FILE_AW-1:0] bank_addr(input logic [BANK_W-1:0] bank,
                                                   input logic [SLOT_W-1:0] slot);
    return {~bank, slot};
  endfunction

  function automatic logic [WORD_W-1:0] pair_join(input logic [BYTE_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [WORD_W-1:0] sp_align(input logic [WORD_W-1:0] v);
    return v & 16'hFFFE;
  endfunction

  function automatic logic cond_eval(input logic [COND_W-1:0] sel,
                                     input logic z, input logic cy,
                                     input logic nonzero);
    case (sel)
      CC_NONZERO: return nonzero;
      CC_ISZERO:  return !nonzero;
      CC_CARRY:   return cy;
      CC_NOCARRY: return !cy;
      CC_ZFLAG:   return z;
      CC_NOZFLAG: return !z;
      CC_HIGHER:  return !(z || cy);
      default:    return z || cy;
    endcase
  endfunction

endpackage

// File: rtl/bankreg_slot_dec.sv
module bankreg_slot_dec
  import bankreg_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic [BANK_W-1:0]  bank,
  output logic               byte_hit,
  output logic               pair_hit,
  output logic [FILE_AW-1:0] lo_addr,
  output logic [FILE_AW-1:0] hi_addr
);
  logic [SLOT_W-1:0] byte_slot;
  logic [1:0]        pair_idx;
  logic [SLOT_W-1:0] lo_slot;

  assign byte_hit  = (sel >= SEL_X) && (sel <= SEL_H);
  assign pair_hit  = (sel >= SEL_AX) && (sel <= SEL_HL);
  assign byte_slot = SLOT_W'(sel - SEL_X);
  assign pair_idx  = 2'(sel - SEL_AX);
  assign lo_slot   = byte_hit ? byte_slot : {pair_idx, 1'b0};

  assign lo_addr = bank_addr(bank, lo_slot);
  assign hi_addr = bank_addr(bank, {pair_idx, 1'b1});
endmodule

// File: rtl/bankreg_store.sv
module bankreg_store #(
  parameter int              DATA_W = 8,
  parameter int              DEPTH  = 32,
  parameter logic [DATA_W-1:0] FILL = '0,
  localparam int             AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_lo,
  input  logic [AW-1:0]     wa_lo,
  input  logic [DATA_W-1:0] wd_lo,
  input  logic              we_hi,
  input  logic [AW-1:0]     wa_hi,
  input  logic [DATA_W-1:0] wd_hi,
  input  logic [AW-1:0]     ra_lo,
  input  logic [AW-1:0]     ra_hi,
  input  logic [AW-1:0]     ra_dbg,
  output logic [DATA_W-1:0] rd_lo,
  output logic [DATA_W-1:0] rd_hi,
  output logic [DATA_W-1:0] rd_dbg
);
  logic [DEPTH-1:0][DATA_W-1:0] cells;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic              hit_lo;
    logic              hit_hi;
    logic [DATA_W-1:0] cell_q;

    assign hit_lo = we_lo && (wa_lo == AW'(gi));
    assign hit_hi = we_hi && (wa_hi == AW'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cell_q <= FILL;
      else if (hit_hi) cell_q <= wd_hi;
      else if (hit_lo) cell_q <= wd_lo;
    end

    assign cells[gi] = cell_q;
  end

  assign rd_lo  = cells[ra_lo];
  assign rd_hi  = cells[ra_hi];
  assign rd_dbg = cells[ra_dbg];
endmodule

// File: rtl/bankreg_special.sv
module bankreg_special
  import bankreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  output logic [BYTE_W-1:0] psw_q,
  output logic [WORD_W-1:0] sp_value,
  output logic              sp_misalign
);
  logic [BYTE_W-1:0] sp_lo_q, sp_hi_q, es_q, cs_q, pmc_q, mem_q;
  logic              misalign_q;
  logic [WORD_W-1:0] sp_next;
  logic              sp_odd_wr;

  assign sp_next   = sp_align(wr_data);
  assign sp_odd_wr = wr_en && (wr_sel == SEL_SP) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q   <= PSW_RST;
      sp_lo_q <= SP_RST[7:0];
      sp_hi_q <= SP_RST[15:8];
      es_q    <= ES_RST;
      cs_q    <= CS_RST;
      pmc_q   <= PMC_RST;
      mem_q   <= MEM_RST;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PSW: psw_q <= wr_data[7:0];
        SEL_SP: begin
          sp_lo_q <= sp_next[7:0];
          sp_hi_q <= sp_next[15:8];
        end
        SEL_ES:  es_q  <= wr_data[7:0];
        SEL_CS:  cs_q  <= wr_data[7:0];
        SEL_PMC: pmc_q <= wr_data[7:0];
        SEL_MEM: mem_q <= wr_data[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) misalign_q <= 1'b0;
    else        misalign_q <= sp_odd_wr;
  end

  assign sp_value    = pair_join(sp_hi_q, sp_lo_q);
  assign sp_misalign = misalign_q;

  always_comb begin
    case (rd_sel)
      SEL_PSW: rd_data = {8'h00, psw_q};
      SEL_SP:  rd_data = sp_value;
      SEL_ES:  rd_data = {8'h00, es_q};
      SEL_CS:  rd_data = {8'h00, cs_q};
      SEL_PMC: rd_data = {8'h00, pmc_q};
      SEL_MEM: rd_data = {8'h00, mem_q};
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/bankreg_cond.sv
module bankreg_cond
  import bankreg_pkg::*;
(
  input  logic [COND_W-1:0] cond_sel,
  input  logic              flag_z,
  input  logic              flag_cy,
  input  logic [WORD_W-1:0] operand,
  output logic              cond_true
);
  logic op_nonzero;

  assign op_nonzero = |operand;
  assign cond_true  = cond_eval(cond_sel, flag_z, flag_cy, op_nonzero);
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
  import bankreg_pkg::*;
#(
  parameter logic [7:0] RESET_FILL = FILL_RST
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic [FILE_AW-1:0] dbg_addr,
  output logic [BYTE_W-1:0] dbg_data,
  input  logic [COND_W-1:0] cond_sel,
  input  logic [WORD_W-1:0] cond_operand,
  output logic              cond_true,
  output logic              sp_misalign
);
  // named internal events, also watched by the checker
  logic [BYTE_W-1:0]  psw_q;
  logic [WORD_W-1:0]  sp_value;
  logic [BANK_W-1:0]  act_bank;
  logic               wr_byte_hit, wr_pair_hit;
  logic               rd_byte_hit, rd_pair_hit;
  logic               wr_lo_en, wr_hi_en;
  logic [FILE_AW-1:0] wr_lo_addr, wr_hi_addr;
  logic [FILE_AW-1:0] rd_lo_addr, rd_hi_addr;
  logic [BYTE_W-1:0]  rd_lo_byte, rd_hi_byte;
  logic [WORD_W-1:0]  spec_rd;

  assign act_bank = {psw_q[ST_BNK1], psw_q[ST_BNK0]};

  bankreg_slot_dec u_wr_dec (
    .sel      (wr_sel),
    .bank     (act_bank),
    .byte_hit (wr_byte_hit),
    .pair_hit (wr_pair_hit),
    .lo_addr  (wr_lo_addr),
    .hi_addr  (wr_hi_addr)
  );

  bankreg_slot_dec u_rd_dec (
    .sel      (rd_sel),
    .bank     (act_bank),
    .byte_hit (rd_byte_hit),
    .pair_hit (rd_pair_hit),
    .lo_addr  (rd_lo_addr),
    .hi_addr  (rd_hi_addr)
  );

  assign wr_lo_en = wr_en && (wr_byte_hit || wr_pair_hit);
  assign wr_hi_en = wr_en && wr_pair_hit;

  bankreg_store #(
    .DATA_W (BYTE_W),
    .DEPTH  (FILE_SZ),
    .FILL   (RESET_FILL)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_lo  (wr_lo_en),
    .wa_lo  (wr_lo_addr),
    .wd_lo  (wr_data[7:0]),
    .we_hi  (wr_hi_en),
    .wa_hi  (wr_hi_addr),
    .wd_hi  (wr_data[15:8]),
    .ra_lo  (rd_lo_addr),
    .ra_hi  (rd_hi_addr),
    .ra_dbg (dbg_addr),
    .rd_lo  (rd_lo_byte),
    .rd_hi  (rd_hi_byte),
    .rd_dbg (dbg_data)
  );

  bankreg_special u_spec (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_sel      (wr_sel),
    .wr_data     (wr_data),
    .rd_sel      (rd_sel),
    .rd_data     (spec_rd),
    .psw_q       (psw_q),
    .sp_value    (sp_value),
    .sp_misalign (sp_misalign)
  );

  bankreg_cond u_cond (
    .cond_sel  (cond_sel),
    .flag_z    (psw_q[ST_Z]),
    .flag_cy   (psw_q[ST_CY]),
    .operand   (cond_operand),
    .cond_true (cond_true)
  );

  always_comb begin
    if (rd_pair_hit)      rd_data = pair_join(rd_hi_byte, rd_lo_byte);
    else if (rd_byte_hit) rd_data = {8'h00, rd_lo_byte};
    else                  rd_data = spec_rd;
  end
endmodule

// File: rtl/bankreg_chk.sv
module bankreg_chk
  import bankreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [SEL_W-1:0]  wr_sel,
  input logic [WORD_W-1:0] wr_data,
  input logic [SEL_W-1:0]  rd_sel,
  input logic [WORD_W-1:0] rd_data,
  input logic [COND_W-1:0] cond_sel,
  input logic              cond_true,
  input logic              sp_misalign,
  input logic [BYTE_W-1:0] psw_q,
  input logic [WORD_W-1:0] sp_value,
  input logic              wr_lo_en,
  input logic [BANK_W-1:0] wr_lo_bank
);
  // R1
  reset_psw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (psw_q == PSW_RST));

  // R5
  psw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_PSW) |=> (psw_q == $past(wr_data[7:0])));

  // R6
  sp_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SP) |=> (sp_value == ($past(wr_data) & 16'hFFFE)));

  // R7
  misalign_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_SP && wr_data[0]) |=> sp_misalign);

  // R7
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == SEL_SP && wr_data[0]) |=> !sp_misalign);

  // R2
  write_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo_en |-> (wr_lo_bank == ~{psw_q[ST_BNK1], psw_q[ST_BNK0]}));

  // R9
  none_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == SEL_NONE) |-> (rd_data == 16'h0000));

  // R10
  higher_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == CC_HIGHER) |-> (cond_true == !(psw_q[ST_Z] || psw_q[ST_CY])));
endmodule

bind bankreg_file bankreg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_sel      (wr_sel),
  .wr_data     (wr_data),
  .rd_sel      (rd_sel),
  .rd_data     (rd_data),
  .cond_sel    (cond_sel),
  .cond_true   (cond_true),
  .sp_misalign (sp_misalign),
  .psw_q       (psw_q),
  .sp_value    (sp_value),
  .wr_lo_en    (wr_lo_en),
  .wr_lo_bank  (wr_lo_addr[4:3])
);

// File: tb/sim_bankreg_file.sv
`timescale 1ns/1ps
module sim_bankreg_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic [4:0]  dbg_addr = '0;
  logic [7:0]  dbg_data;
  logic [2:0]  cond_sel = '0;
  logic [15:0] cond_operand = '0;
  logic        cond_true;
  logic        sp_misalign;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] model [32];
  logic [7:0] m_psw;

  always #2 clk = ~clk;

  bankreg_file u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_sel (wr_sel),
    .wr_data (wr_data), .rd_sel (rd_sel), .rd_data (rd_data),
    .dbg_addr (dbg_addr), .dbg_data (dbg_data), .cond_sel (cond_sel),
    .cond_operand (cond_operand), .cond_true (cond_true),
    .sp_misalign (sp_misalign)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [4:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic get(input logic [4:0] sel, output logic [15:0] v);
    rd_sel = sel; #0.2; v = rd_data;
  endtask

  task automatic peek(input int a, output logic [7:0] v);
    dbg_addr = 5'(a); #0.2; v = dbg_data;
  endtask

  function automatic int base_of(input int b);
    return (3 - b) * 8;
  endfunction

  function automatic logic [7:0] psw_for(input int b, input int z, input int cy);
    return 8'(((b / 2) << 5) + ((b % 2) << 3) + (z << 6) + cy);
  endfunction

  task automatic sweep(input string req);
    logic [7:0] v;
    for (int a = 0; a < 32; a++) begin
      peek(a, v);
      chk(req, $sformatf("flat byte %0d", a), {8'h00, v}, {8'h00, model[a]});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  bv;
    for (int a = 0; a < 32; a++) model[a] = 8'h11;
    m_psw = 8'h06;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    sweep("R1");
    get(5'd13, v); chk("R1", "status reset", v, 16'h0006);
    get(5'd15, v); chk("R1", "ES reset", v, 16'h000F);
    get(5'd16, v); chk("R1", "CS reset", v, 16'h0000);
    get(5'd17, v); chk("R1", "PMC reset", v, 16'h0000);
    get(5'd18, v); chk("R1", "MEM reset", v, 16'h0000);
    get(5'd14, v); chk("R1", "SP reset", v, 16'h0000);
    chk("R1", "misalign reset", {15'd0, sp_misalign}, 16'h0000);
    get(5'd1, v);  chk("R1", "X in bank 0", v, 16'h0011);

    // R2 R4 byte writes in every bank, junk in the upper half of wr_data
    for (int b = 0; b < 4; b++) begin
      m_psw = psw_for(b, 0, 0);
      put(5'd13, {8'hE7, m_psw});
      for (int s = 0; s < 8; s++) begin
        bv = 8'(8'h40 + b * 16 + s * 3);
        put(5'(s + 1), {8'hA5, bv});
        model[base_of(b) + s] = bv;
      end
      for (int s = 0; s < 8; s++) begin
        get(5'(s + 1), v);
        chk("R4", $sformatf("bank %0d byte code %0d", b, s + 1), v,
            {8'h00, model[base_of(b) + s]});
      end
      for (int p = 0; p < 4; p++) begin
        get(5'(9 + p), v);
        chk("R3", $sformatf("bank %0d pair read %0d", b, p), v,
            {model[base_of(b) + 2 * p + 1], model[base_of(b) + 2 * p]});
      end
    end
    sweep("R2");

    // R3 pair writes
    for (int b = 0; b < 4; b++) begin
      m_psw = psw_for(b, 0, 0);
      put(5'd13, {8'h00, m_psw});
      for (int p = 0; p < 4; p++) begin
        v = {8'(8'h90 + b * 8 + 2 * p + 1), 8'(8'h20 + b * 8 + 2 * p)};
        put(5'(9 + p), v);
        model[base_of(b) + 2 * p + 1] = v[15:8];
        model[base_of(b) + 2 * p]     = v[7:0];
      end
      for (int p = 0; p < 4; p++) begin
        get(5'(9 + p), v);
        chk("R3", $sformatf("bank %0d pair %0d", b, p), v,
            {model[base_of(b) + 2 * p + 1], model[base_of(b) + 2 * p]});
        get(5'(2 * p + 2), v);
        chk("R3", $sformatf("bank %0d high byte of pair %0d", b, p), v,
            {8'h00, model[base_of(b) + 2 * p + 1]});
      end
    end
    sweep("R3");

    // R5 bank switch timing: old bank during the write, new bank after the edge
    @(negedge clk);
    rd_sel = 5'd1;
    wr_en = 1'b1; wr_sel = 5'd13; wr_data = {8'h00, psw_for(2, 0, 0)};
    #1;
    chk("R5", "X during status write", rd_data, {8'h00, model[base_of(3)]});
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R5", "X after status write", rd_data, {8'h00, model[base_of(2)]});
    put(5'd8, 16'h00C3);
    model[base_of(2) + 7] = 8'hC3;
    sweep("R5");

    // R8 special byte registers
    put(5'd15, 16'hFF3C); get(5'd15, v); chk("R8", "ES", v, 16'h003C);
    put(5'd16, 16'h125A); get(5'd16, v); chk("R8", "CS", v, 16'h005A);
    put(5'd17, 16'h8801); get(5'd17, v); chk("R8", "PMC", v, 16'h0001);
    put(5'd18, 16'h77E2); get(5'd18, v); chk("R8", "MEM", v, 16'h00E2);
    m_psw = psw_for(1, 0, 0) | 8'h94;
    put(5'd13, {8'h33, m_psw}); get(5'd13, v); chk("R8", "status", v, {8'h00, m_psw});
    get(5'd1, v); chk("R2", "X in bank 1 with other status bits set", v,
                      {8'h00, model[base_of(1)]});

    // R6 R7 stack pointer
    put(5'd14, 16'h1235);
    chk("R7", "pulse after odd SP write", {15'd0, sp_misalign}, 16'h0001);
    get(5'd14, v); chk("R6", "odd SP value", v, 16'h1234);
    @(negedge clk); #1;
    chk("R7", "pulse drops after one cycle", {15'd0, sp_misalign}, 16'h0000);
    put(5'd14, 16'hBEEE);
    chk("R7", "no pulse on even SP write", {15'd0, sp_misalign}, 16'h0000);
    get(5'd14, v); chk("R6", "even SP value", v, 16'hBEEE);
    put(5'd14, 16'hFFFF);
    chk("R7", "pulse on 0xFFFF", {15'd0, sp_misalign}, 16'h0001);
    get(5'd14, v); chk("R6", "SP 0xFFFF", v, 16'hFFFE);
    put(5'd15, 16'h0001);
    chk("R7", "no pulse on ES write with bit 0", {15'd0, sp_misalign}, 16'h0000);

    // R9 unassigned codes
    put(5'd0, 16'hFFFF);
    for (int c = 19; c < 32; c++) put(5'(c), 16'hFFFF);
    sweep("R9");
    get(5'd13, v); chk("R9", "status untouched", v, {8'h00, m_psw});
    get(5'd14, v); chk("R9", "SP untouched", v, 16'hFFFE);
    get(5'd15, v); chk("R9", "ES untouched", v, 16'h0001);
    get(5'd18, v); chk("R9", "MEM untouched", v, 16'h00E2);
    get(5'd0, v);  chk("R9", "code 0 reads zero", v, 16'h0000);
    for (int c = 19; c < 32; c++) begin
      get(5'(c), v); chk("R9", $sformatf("code %0d reads zero", c), v, 16'h0000);
    end

    // R10 R11 conditions over all flag pairs and operands
    for (int f = 0; f < 4; f++) begin
      int z = f / 2;
      int cy = f % 2;
      put(5'd13, {8'h00, psw_for(0, z, cy)});
      for (int c = 2; c < 8; c++) begin
        logic e;
        case (c)
          2: e = (cy == 1);
          3: e = (cy == 0);
          4: e = (z == 1);
          5: e = (z == 0);
          6: e = (z + cy == 0);
          default: e = (z + cy > 0);
        endcase
        cond_sel = 3'(c); #0.2;
        chk("R10", $sformatf("cond %0d z=%0d cy=%0d", c, z, cy),
            {15'd0, cond_true}, {15'd0, e});
      end
      for (int k = 0; k < 3; k++) begin
        logic [15:0] op;
        op = (k == 0) ? 16'h0000 : (k == 1) ? 16'h0001 : 16'h8000;
        cond_operand = op;
        cond_sel = 3'd0; #0.2;
        chk("R11", $sformatf("true test op=%h", op), {15'd0, cond_true},
            {15'd0, (op != 0)});
        cond_sel = 3'd1; #0.2;
        chk("R11", $sformatf("false test op=%h", op), {15'd0, cond_true},
            {15'd0, (op == 0)});
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule